// File: doc/BRIEF.md
# Sliding-Window Integer Register File

This block holds the integer registers of a processor core that uses sliding register windows. Software always addresses 32 registers with a 5-bit index, but only eight of those (the globals) are fixed; the other 24 are mapped onto a larger physical array through a current-window pointer. Each window owns eight private locals. It overlaps its neighbours by eight registers on each side. Because of this overlap, the values a caller places in its outgoing registers appear in the callee's incoming registers without any copying.

The block has two combinational read ports and one synchronous write port. A write lands at the rising clock edge, and a read of the register being written in the same cycle returns the new value. The save and restore inputs step the window pointer down or up by one, wrapping around the ring of windows. An input mask marks windows whose contents are not resident. A move into a marked window is refused: the pointer stays where it is, and a spill or fill fault flag pulses so that a trap handler elsewhere can act on it.

Top module: `winreg_file`

## Requirements
- R1: Indices 0 to 7 are global. Indices 1 to 7 address the same storage in every window.
- R2: Index 0 always reads as zero on both read ports, including in a cycle where it is being written. Writes to index 0 are dropped.
- R3: Indices 16 to 23 are locals, private to the current window. A write to a local in one window leaves the same local of any other window unchanged.
- R4: Index 8+k (out k) of window w is the same storage as index 24+k (in k) of window (w-1) mod NWIN, for k = 0 to 7.
- R5: A save moves the pointer `cwp` to (cwp-1) mod NWIN and a restore moves it to (cwp+1) mod NWIN, visible from the next cycle. Reads and writes in the request cycle use the old window.
- R6: After reset `cwp` is 0 and both fault flags are low.
- R7: A save whose target window has its bit set in `invalid_mask` (bit i stands for window i) leaves `cwp` unchanged and drives `spill_fault` high for exactly the following cycle.
- R8: A restore whose target window has its bit set in `invalid_mask` leaves `cwp` unchanged and drives `fill_fault` high for exactly the following cycle.
- R9: A read whose index matches the index being written in the same cycle returns the write data (write-first bypass).
- R10: When save and restore are asserted together, the pointer does not move and neither fault flag is raised.
- R11: The two read ports are independent. Each returns its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A architectural index |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B architectural index |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural index |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move window down (call) |
| restore_req | input | 1 | Move window up (return) |
| invalid_mask | input | NWIN | Per-window non-resident marks |
| cwp | output | $clog2(NWIN) | Current window pointer |
| spill_fault | output | 1 | Refused save, one-cycle pulse |
| fill_fault | output | 1 | Refused restore, one-cycle pulse |

## Verification
Values are written into globals, locals, outs and ins, and read back after the window has moved. This separates shared storage from private storage, and it shows whether out-to-in aliasing points to the correct neighbour, including across the wrap from window 0 to the top window. A full ring of saves followed by restores checks the modulo arithmetic of the pointer. Masked targets in both directions, simultaneous save and restore, a write issued in the same cycle as a save, and same-cycle read-after-write tell refusal, priority, old-window addressing and bypass apart from ordinary updates.

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4:0]               rd_a_idx,
  output logic [XLEN-1:0]          rd_a_data,
  input  logic [4:0]               rd_b_idx,
  output logic [XLEN-1:0]          rd_b_data,
  input  logic                     wr_en,
  input  logic [4:0]               wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     save_req,
  input  logic                     restore_req,
  input  logic [NWIN-1:0]          invalid_mask,
  output logic [$clog2(NWIN)-1:0]  cwp,
  output logic                     spill_fault,
  output logic                     fill_fault
);
  localparam int NPHYS = 8 + 16 * NWIN;
  localparam int PAW   = $clog2(NPHYS);
  localparam int CWW   = $clog2(NWIN);
  localparam logic [CWW-1:0] TOP = CWW'(NWIN - 1);

  logic [XLEN-1:0] regs [NPHYS];
  logic [PAW-1:0]  pa_a, pa_b, pa_w;
  logic [CWW-1:0]  cwp_dn, cwp_up;
  logic            do_save, do_rest;

  function automatic logic [PAW-1:0] xlate(input logic [4:0] idx, input logic [CWW-1:0] w);
    int win;
    int base;
    win = int'(w);
    case (idx[4:3])
      2'b00:   base = 0;
      2'b01:   base = 16 + 16 * ((win == 0) ? NWIN - 1 : win - 1);
      2'b10:   base = 8 + 16 * win;
      default: base = 16 + 16 * win;
    endcase
    return PAW'(base + int'(idx[2:0]));
  endfunction

  assign pa_a = xlate(rd_a_idx, cwp);
  assign pa_b = xlate(rd_b_idx, cwp);
  assign pa_w = xlate(wr_idx, cwp);

  assign cwp_dn  = (cwp == '0)  ? TOP : cwp - 1'b1;
  assign cwp_up  = (cwp == TOP) ? '0  : cwp + 1'b1;
  assign do_save = save_req & ~restore_req;
  assign do_rest = restore_req & ~save_req;

  always_ff @(posedge clk)
    if (wr_en && wr_idx != 5'd0) regs[pa_w] <= wr_data;

  assign rd_a_data = (rd_a_idx == 5'd0) ? '0 :
                     (wr_en && pa_w == pa_a) ? wr_data : regs[pa_a];
  assign rd_b_data = (rd_b_idx == 5'd0) ? '0 :
                     (wr_en && pa_w == pa_b) ? wr_data : regs[pa_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp         <= '0;
      spill_fault <= 1'b0;
      fill_fault  <= 1'b0;
    end else begin
      spill_fault <= do_save & invalid_mask[cwp_dn];
      fill_fault  <= do_rest & invalid_mask[cwp_up];
      if (do_save && !invalid_mask[cwp_dn]) cwp <= cwp_dn;
      else if (do_rest && !invalid_mask[cwp_up]) cwp <= cwp_up;
    end
  end

  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp) < NWIN);

  assert_save_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req && !invalid_mask[cwp_dn]) |=> (cwp == $past(cwp_dn)));

  assert_no_overflow_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req && invalid_mask[cwp_dn]) |=> (spill_fault && cwp == $past(cwp)));

  assert_no_underflow_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && invalid_mask[cwp_up]) |=> (fill_fault && cwp == $past(cwp)));

  assert_both_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |=> (!spill_fault && !fill_fault && $stable(cwp)));
endmodule

// File: tb/tb_winreg_file.sv
module tb_winreg_file;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  a_idx = '0, b_idx = '0, w_idx = '0;
  logic [31:0] a_data, b_data, w_data = '0;
  logic        we = 1'b0, sv = 1'b0, rs = 1'b0;
  logic [NW-1:0] mask = '0;
  logic [2:0]  cwp;
  logic        spill, fill;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  winreg_file #(.NWIN(NW), .XLEN(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(a_idx), .rd_a_data(a_data),
    .rd_b_idx(b_idx), .rd_b_data(b_data),
    .wr_en(we), .wr_idx(w_idx), .wr_data(w_data),
    .save_req(sv), .restore_req(rs), .invalid_mask(mask),
    .cwp(cwp), .spill_fault(spill), .fill_fault(fill));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] val);
    @(negedge clk); we = 1'b1; w_idx = idx; w_data = val;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] val);
    @(negedge clk); a_idx = idx; #1 val = a_data;
  endtask

  task automatic move(input logic s, input logic r);
    @(negedge clk); sv = s; rs = r;
    @(negedge clk); sv = 1'b0; rs = 1'b0;
  endtask

  task automatic t_reset;
    chk("R6 cwp", 32'(cwp), 0);
    chk("R6 spill", 32'(spill), 0);
    chk("R6 fill", 32'(fill), 0);
  endtask

  task automatic t_globals;
    logic [31:0] v;
    wr(5'd3, 32'h3333_0003);
    move(1'b1, 1'b0);
    rd(5'd3, v); chk("R1 global seen after save", v, 32'h3333_0003);
    move(1'b0, 1'b1);
    chk("R5 back to window 0", 32'(cwp), 0);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    wr(5'd0, 32'hDEAD_BEEF);
    rd(5'd0, v); chk("R2 zero after write", v, 0);
    @(negedge clk); we = 1'b1; w_idx = 5'd0; w_data = 32'h1234_5678; a_idx = 5'd0; b_idx = 5'd0;
    #1 chk("R2 zero during write A", a_data, 0);
    chk("R2 zero during write B", b_data, 0);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic t_locals;
    logic [31:0] v;
    wr(5'd16, 32'h1111_0000);
    move(1'b1, 1'b0);
    wr(5'd16, 32'h7777_0000);
    rd(5'd16, v); chk("R3 local in window 7", v, 32'h7777_0000);
    move(1'b0, 1'b1);
    rd(5'd16, v); chk("R3 local of window 0 kept", v, 32'h1111_0000);
  endtask

  task automatic t_share;
    logic [31:0] v;
    wr(5'd9, 32'h0000_00A9);
    move(1'b1, 1'b0);
    rd(5'd25, v); chk("R4 caller out1 is callee in1", v, 32'h0000_00A9);
    wr(5'd30, 32'h0000_00BE);
    move(1'b0, 1'b1);
    rd(5'd14, v); chk("R4 callee in6 is caller out6", v, 32'h0000_00BE);
    wr(5'd24, 32'h0000_0C24);
    move(1'b0, 1'b1);
    rd(5'd8, v); chk("R4 window1 out0 is window0 in0", v, 32'h0000_0C24);
    move(1'b1, 1'b0);
  endtask

  task automatic t_ring;
    logic [31:0] v;
    for (int k = 1; k <= NW; k++) begin
      move(1'b1, 1'b0);
      chk("R5 save step", 32'(cwp), 32'((NW - k) % NW));
    end
    for (int k = 1; k <= 3; k++) begin
      move(1'b0, 1'b1);
      chk("R5 restore step", 32'(cwp), 32'(k));
    end
    for (int k = 1; k <= 3; k++) move(1'b1, 1'b0);
    @(negedge clk); sv = 1'b1; we = 1'b1; w_idx = 5'd17; w_data = 32'h0BAD_0017;
    @(negedge clk); sv = 1'b0; we = 1'b0;
    chk("R5 cwp after save with write", 32'(cwp), 7);
    move(1'b0, 1'b1);
    rd(5'd17, v); chk("R5 request-cycle write used old window", v, 32'h0BAD_0017);
  endtask

  task automatic t_overflow;
    mask = 8'h80;
    @(negedge clk); sv = 1'b1;
    @(negedge clk); sv = 1'b0;
    chk("R7 spill pulse", 32'(spill), 1);
    chk("R7 cwp held", 32'(cwp), 0);
    @(negedge clk);
    chk("R7 spill one cycle", 32'(spill), 0);
    mask = '0;
  endtask

  task automatic t_underflow;
    mask = 8'h02;
    @(negedge clk); rs = 1'b1;
    @(negedge clk); rs = 1'b0;
    chk("R8 fill pulse", 32'(fill), 1);
    chk("R8 cwp held", 32'(cwp), 0);
    chk("R8 no spill", 32'(spill), 0);
    @(negedge clk);
    chk("R8 fill one cycle", 32'(fill), 0);
    mask = '0;
  endtask

  task automatic t_bypass;
    wr(5'd20, 32'h0000_0001);
    @(negedge clk); we = 1'b1; w_idx = 5'd20; w_data = 32'h5555_AAAA; a_idx = 5'd20; b_idx = 5'd20;
    #1 chk("R9 bypass port A", a_data, 32'h5555_AAAA);
    chk("R9 bypass port B", b_data, 32'h5555_AAAA);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic t_both;
    move(1'b1, 1'b1);
    chk("R10 cwp unchanged", 32'(cwp), 0);
    chk("R10 no spill", 32'(spill), 0);
    chk("R10 no fill", 32'(fill), 0);
  endtask

  task automatic t_ports;
    @(negedge clk); a_idx = 5'd3; b_idx = 5'd16;
    #1 chk("R11 port A", a_data, 32'h3333_0003);
    chk("R11 port B", b_data, 32'h1111_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_globals();
    t_zero();
    t_locals();
    t_share();
    t_ring();
    t_overflow();
    t_underflow();
    t_bypass();
    t_both();
    t_ports();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end
endmodule